// File: doc/BRIEF.md
# ECC Check-Bit Fault Injector

This block sits in a memory controller write path and corrupts ECC check bits on purpose, so that the read-side correction logic can be tested. Software programs two dword registers. The first is a flip mask that covers the check bits of one half cacheline. The second is a control word. The control word arms ECC injection and, separately, address-parity corruption. It also chooses which half cacheline is affected and whether injection repeats.

Write beats arrive one half cacheline at a time. Each beat carries its check bits, a flag that says whether it is the upper half, and a strobe from an external address comparator. The check bits pass through the block combinationally. On a qualifying beat they are XORed with the mask, and the block flags whether the pattern it applied can be corrected or not. A one-shot arming is used up by the first injection. In full-cacheline mode that means both halves of the line. A repeat bit keeps injection active on every qualifying beat.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset both registers read 0 and no beat is altered.
- R2: A write at offset F8h loads the 32-bit mask. A write at offset FCh loads control bits 4:0: bit 4 arms parity, bit 3 arms ECC, bits 2:1 select the half, bit 0 enables repeat. Control bits 31:5 read 0, and any other offset reads 0.
- R3: On an injected beat, `ecc_o` equals `beat_ecc_i` XOR mask in the same cycle. On every other beat, `ecc_o` equals `beat_ecc_i`.
- R4: A beat is injected only when `beat_valid_i`, `beat_match_i` and the ECC arm bit are all 1.
- R5: The half selector works as follows. 01 injects only beats with `beat_upper_i`=0. 10 injects only beats with `beat_upper_i`=1. 11 injects both halves. 00 injects nothing and leaves the ECC arm bit set.
- R6: With repeat 0 and a single-half selector, the ECC arm bit clears after the first injection.
- R7: With repeat 0 and selector 11, the arm bit stays set until each half has been injected once. A further beat of a half that was already injected passes unchanged.
- R8: With repeat 1, every qualifying beat is injected and the ECC arm bit stays set.
- R9: `parity_corrupt_o` is 1 exactly on a valid, matching beat while the parity arm bit is set. That bit then clears unless repeat is 1.
- R10: `uncorr_o` is 1 on an injected beat whose mask has set bits in both 16-bit symbol pairs (15:0 and 31:16). It is 0 when all set bits lie in one pair, and 0 on any beat that is not injected.
- R11: A control write in the same cycle as a self-clear wins: the written value is what remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| beat_valid_i | input | 1 | Write beat present |
| beat_upper_i | input | 1 | Beat is the upper 32-byte half |
| beat_match_i | input | 1 | Address comparator hit for this beat |
| beat_ecc_i | input | 32 | Check bits of the beat |
| ecc_o | output | 32 | Check bits, possibly flipped |
| ecc_flipped_o | output | 1 | Mask applied to this beat |
| uncorr_o | output | 1 | Applied pattern is uncorrectable |
| parity_corrupt_o | output | 1 | Request to corrupt address parity |

## Verification
The hardest states to reach are the partial states of a one-shot full-cacheline arming. In those, one half has been injected and the other has not. Repeat beats of the finished half must pass through clean, and a control write can land in the very cycle that would complete the arming. Directed sequences drive upper, upper again, then lower, and also a write coinciding with a completing beat. Random traffic mixes halves, strobes and rewrites of the control word, so these partial states recur many times.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int MASK_W = 32;
  localparam int PAIR_W = 16;
  localparam int ADDR_W = 8;
  localparam int CTRL_W = 5;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'hF8;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'hFC;

  typedef struct packed {
    logic       par_arm;
    logic       ecc_arm;
    logic [1:0] half_sel;
    logic       repeat_en;
  } ctrl_t;
endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
  import ecc_inj_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MASK_W-1:0] wdata_i,
  output logic [MASK_W-1:0] rdata_o,
  output logic [MASK_W-1:0] mask_o,
  output ctrl_t             ctrl_o,
  output logic [1:0]        done_o,
  input  logic              ecc_fire_i,
  input  logic              fire_upper_i,
  input  logic              par_fire_i
);
  ctrl_t      ctrl_q;
  logic [1:0] done_q;
  logic [MASK_W-1:0] mask_q;
  logic       wr_mask, wr_ctrl;
  logic [1:0] hit_bit, done_nxt;

  assign wr_mask  = wr_en_i && (addr_i == OFF_MASK);
  assign wr_ctrl  = wr_en_i && (addr_i == OFF_CTRL);
  assign hit_bit  = fire_upper_i ? 2'b10 : 2'b01;
  assign done_nxt = done_q | hit_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      done_q <= '0;
    end else if (wr_ctrl) begin
      // software write beats any self-clear
      ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      done_q <= '0;
    end else begin
      if (par_fire_i && !ctrl_q.repeat_en) ctrl_q.par_arm <= 1'b0;
      if (ecc_fire_i && !ctrl_q.repeat_en) begin
        if ((done_nxt & ctrl_q.half_sel) == ctrl_q.half_sel) begin
          ctrl_q.ecc_arm <= 1'b0;
          done_q         <= '0;
        end else begin
          done_q <= done_nxt;
        end
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_MASK: rdata_o = mask_q;
      OFF_CTRL: rdata_o = {{(MASK_W-CTRL_W){1'b0}}, ctrl_q};
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;
  assign done_o = done_q;

  AST_ONESHOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_fire_i && !ctrl_q.repeat_en && !wr_ctrl && ctrl_q.half_sel != 2'b11) |=> !ctrl_q.ecc_arm); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_fire_i && !ctrl_q.repeat_en && !wr_ctrl && ctrl_q.half_sel == 2'b11 && done_q == 2'b00) |=> ctrl_q.ecc_arm); // R7
  AST_REPEAT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.ecc_arm && ctrl_q.repeat_en && !wr_ctrl) |=> ctrl_q.ecc_arm); // R8
  AST_PAR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_fire_i && !ctrl_q.repeat_en && !wr_ctrl) |=> !ctrl_q.par_arm); // R9
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (ctrl_q == ctrl_t'($past(wdata_i[CTRL_W-1:0])))); // R11
endmodule

// File: rtl/ecc_inj_classify.sv
module ecc_inj_classify
  import ecc_inj_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MASK_W-1:0] mask_i,
  output logic              uncorr_o
);
  localparam int NPAIR = MASK_W / PAIR_W;
  logic [NPAIR-1:0] pair_nz;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_nz[p] = |mask_i[p*PAIR_W +: PAIR_W];
  end

  // more than one symbol pair touched: beyond correction
  assign uncorr_o = ($countones(pair_nz) > 1);

  AST_UNCORR_MULTI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> ($countones(mask_i) > 1)); // R10
endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
  import ecc_inj_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [MASK_W-1:0] reg_wdata_i,
  output logic [MASK_W-1:0] reg_rdata_o,
  input  logic              beat_valid_i,
  input  logic              beat_upper_i,
  input  logic              beat_match_i,
  input  logic [MASK_W-1:0] beat_ecc_i,
  output logic [MASK_W-1:0] ecc_o,
  output logic              ecc_flipped_o,
  output logic              uncorr_o,
  output logic              parity_corrupt_o
);
  logic [MASK_W-1:0] mask;
  ctrl_t             ctrl;
  logic [1:0]        done;
  logic              half_sel, half_open, qual, ecc_fire, par_fire, mask_uncorr;

  ecc_inj_regs u_regs (
    .clk_i, .rst_ni,
    .wr_en_i     (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .mask_o      (mask),
    .ctrl_o      (ctrl),
    .done_o      (done),
    .ecc_fire_i  (ecc_fire),
    .fire_upper_i(beat_upper_i),
    .par_fire_i  (par_fire)
  );

  ecc_inj_classify u_cls (
    .clk_i, .rst_ni,
    .mask_i  (mask),
    .uncorr_o(mask_uncorr)
  );

  assign qual      = beat_valid_i && beat_match_i;
  assign half_sel  = beat_upper_i ? ctrl.half_sel[1] : ctrl.half_sel[0];
  // in one-shot full mode a finished half is not hit again
  assign half_open = ctrl.repeat_en || !done[beat_upper_i];
  assign ecc_fire  = qual && ctrl.ecc_arm && half_sel && half_open;
  assign par_fire  = qual && ctrl.par_arm;

  assign ecc_o            = ecc_fire ? (beat_ecc_i ^ mask) : beat_ecc_i;
  assign ecc_flipped_o    = ecc_fire;
  assign uncorr_o         = ecc_fire && mask_uncorr;
  assign parity_corrupt_o = par_fire;

  AST_NO_ARM_NO_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_flipped_o |-> (ctrl.ecc_arm && beat_match_i && beat_valid_i)); // R4
  AST_SEL_NONE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.half_sel == 2'b00) |-> (!ecc_flipped_o && ecc_o == beat_ecc_i)); // R5
  AST_PASS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ecc_flipped_o |-> (ecc_o == beat_ecc_i && !uncorr_o)); // R3
  AST_PAR_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_corrupt_o |-> (beat_valid_i && beat_match_i)); // R9
endmodule

// File: tb/sim_ecc_inject_ctrl.sv
module sim_ecc_inject_ctrl;
  logic clk_i = 0, rst_ni = 0;
  logic reg_we_i = 0;
  logic [7:0] reg_addr_i = 8'hFC;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic beat_valid_i = 0, beat_upper_i = 0, beat_match_i = 0;
  logic [31:0] beat_ecc_i = 0, ecc_o;
  logic ecc_flipped_o, uncorr_o, parity_corrupt_o;

  int n_chk = 0, n_err = 0;

  // bench model of the registers
  logic [31:0] m_mask = 0;
  logic [4:0]  m_ctrl = 0;
  logic [1:0]  m_done = 0;

  always #5 clk_i = ~clk_i;

  ecc_inject_ctrl u0 (.*);

  function automatic logic span_two(input logic [31:0] m);
    return (|m[15:0]) && (|m[31:16]);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock cycle: drive at negedge, sample before posedge, advance model
  task automatic cyc(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                     input logic bv, input logic bu, input logic bm, input logic [31:0] be);
    logic hs, fire, pfire, rep;
    logic [1:0] hb, dn;
    logic [31:0] exp_rd, exp_ecc;
    @(negedge clk_i);
    reg_we_i = we; reg_addr_i = addr; reg_wdata_i = wd;
    beat_valid_i = bv; beat_upper_i = bu; beat_match_i = bm; beat_ecc_i = be;
    #2;
    rep   = m_ctrl[0];
    hs    = bu ? m_ctrl[2] : m_ctrl[1];
    fire  = bv && bm && m_ctrl[3] && hs && (rep || !m_done[bu]);
    pfire = bv && bm && m_ctrl[4];
    exp_ecc = fire ? (be ^ m_mask) : be;
    exp_rd  = (addr == 8'hF8) ? m_mask : (addr == 8'hFC) ? {27'b0, m_ctrl} : 32'h0;
    check(ecc_o == exp_ecc, "R3", ecc_o, exp_ecc);
    check(ecc_flipped_o == fire, "R4", {31'b0, ecc_flipped_o}, {31'b0, fire});
    check(uncorr_o == (fire && span_two(m_mask)), "R10", {31'b0, uncorr_o}, {31'b0, fire && span_two(m_mask)});
    check(parity_corrupt_o == pfire, "R9", {31'b0, parity_corrupt_o}, {31'b0, pfire});
    check(reg_rdata_o == exp_rd, "R2", reg_rdata_o, exp_rd);
    if (we && addr == 8'hF8) m_mask = wd;
    if (we && addr == 8'hFC) begin
      m_ctrl = wd[4:0]; m_done = 0;
    end else begin
      if (pfire && !rep) m_ctrl[4] = 0;
      if (fire && !rep) begin
        hb = bu ? 2'b10 : 2'b01;
        dn = m_done | hb;
        if ((dn & m_ctrl[2:1]) == m_ctrl[2:1]) begin
          m_ctrl[3] = 0; m_done = 0;
        end else m_done = dn;
      end
    end
    @(posedge clk_i);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 0, 32'h0);
  endtask

  task automatic beat(input logic bu, input logic bm, input logic [31:0] be);
    cyc(0, 8'hFC, 0, 1, bu, bm, be);
  endtask

  task automatic expect_ctrl(input logic [4:0] e, input string req);
    @(negedge clk_i);
    reg_we_i = 0; reg_addr_i = 8'hFC; beat_valid_i = 0;
    #2 check(reg_rdata_o == {27'b0, e}, req, reg_rdata_o, {27'b0, e});
  endtask

  function automatic logic [31:0] rnd_mask();
    logic [31:0] r = $urandom;
    case (r[1:0])
      2'd0: return 32'h1 << r[7:3];
      2'd1: return {16'h0, r[31:16] | 16'h1};
      2'd2: return {r[31:16] | 16'h1, 16'h0};
      default: return r | 32'h0001_0001;
    endcase
  endfunction

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    #22 rst_ni = 1;
    // R1 reset state
    expect_ctrl(5'h00, "R1");
    @(negedge clk_i); reg_addr_i = 8'hF8;
    #2 check(reg_rdata_o == 0, "R1", reg_rdata_o, 0);
    beat(0, 1, 32'hDEAD_BEEF);
    // R6 one-shot lower half
    wr(8'hF8, 32'h0000_0001);
    wr(8'hFC, 32'hFFFF_FF0A);
    check(reg_rdata_o == 32'h0, "R2", reg_rdata_o, 32'h0);
    expect_ctrl(5'h0A, "R2");
    beat(1, 1, 32'h1234_5678);
    beat(0, 0, 32'h1234_5678);
    beat(0, 1, 32'h1234_5678);
    expect_ctrl(5'h02, "R6");
    // R5 selector 00 keeps arm
    wr(8'hFC, 32'h08);
    beat(0, 1, 32'hAAAA_0000);
    beat(1, 1, 32'hAAAA_0000);
    expect_ctrl(5'h08, "R5");
    // R7 full mode one-shot, R10 spanning mask
    wr(8'hF8, 32'h0001_0100);
    wr(8'hFC, 32'h0E);
    beat(1, 1, 32'h0);
    expect_ctrl(5'h0E, "R7");
    beat(1, 1, 32'h0);
    beat(0, 1, 32'h0);
    expect_ctrl(5'h06, "R7");
    // R8 repeat
    wr(8'hF8, 32'h0000_8001);
    wr(8'hFC, 32'h0B);
    for (int i = 0; i < 4; i++) beat(0, 1, 32'h5555_5555);
    beat(0, 0, 32'h5555_5555);
    expect_ctrl(5'h0B, "R8");
    // R9 parity one-shot
    wr(8'hFC, 32'h10);
    beat(0, 0, 32'h0);
    beat(1, 1, 32'h0);
    beat(1, 1, 32'h0);
    expect_ctrl(5'h00, "R9");
    // R11 write collides with self-clear
    wr(8'hFC, 32'h0A);
    cyc(1, 8'hFC, 32'h0A, 1, 0, 1, 32'h0F0F_0F0F);
    expect_ctrl(5'h0A, "R11");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      if (r[3:0] == 0) wr(8'hF8, rnd_mask());
      else if (r[3:0] == 1) wr(8'hFC, {27'b0, r[8:4]});
      else if (r[3:0] == 2) cyc(1, 8'hFC, {27'b0, r[8:4]}, 1, r[9], r[10], $urandom);
      else cyc(0, r[11] ? 8'hFC : 8'hF8, 0, r[12] | r[13], r[9], r[10] | r[14], $urandom);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule